// File: doc/BRIEF.md
# Buffered Configuration Port Writer

This peripheral sits between a processor's simple register bus and a 16-bit internal configuration port. Software loads configuration words one at a time into a 64-entry write buffer. It then writes a start value to the control register. The block moves the buffered words to the port, one word per cycle, and holds a word in place for as long as the port signals busy. Software polls a done flag in the status register, or watches the self-clearing write bit in the control register, to learn that the transfer has finished.

A second control bit aborts the operation. It stops any transfer in progress, drops every buffered word and clears the overflow flag. The status register also reports how many buffer entries are free, so that software can avoid overflow. A sticky flag records any write that was lost because the buffer was full.

Top module: `cfg_port_writer`

## Requirements
- R1: After reset, port_en and port_wr are low, the control register reads 0, and the status register reads the vacancy field equal to FIFO_DEPTH (64) with done (bit 0) and overflow (bit 1) clear.
- R2: Register word addresses are 0 = control, 1 = status and 2 = buffer data (write only). bus_rdata presents the selected register on the cycle after the cycle in which bus_rd is high. Control bit 0 is the write bit and bit 1 is the abort bit. Status bit 0 is done, bit 1 is overflow, and bits starting at bit 8 hold the vacancy count.
- R3: A write to address 2 stores the low 16 bits of bus_wdata in the buffer, and the vacancy count drops by one.
- R4: Writing the control register with bit 0 set and bit 1 clear starts a transfer. The write bit reads 1 from the next cycle, and the done bit reads 0 from the next cycle.
- R5: Buffered words appear on port_data in the order they were written. While a word is presented, port_en and port_wr are high. When busy stays low, one word moves per cycle.
- R6: A word is taken by the port on a cycle where port_en is high and port_busy is low. While port_busy is high, port_en stays high and port_data does not change.
- R7: The cycle after the last word is taken, the write bit clears, done sets and port_en falls. Done stays set until the next start.
- R8: A write to a full buffer is dropped and sets the overflow flag. The flag stays set until an abort, and the words already held are transferred unchanged.
- R9: An abort stops the transfer, empties the buffer, lowers port_en and clears overflow. It does not set done.
- R10: After an abort write, the abort bit reads 1 for exactly two cycles (the flush cycle and one more) and then clears by itself. Buffer data writes and start requests made while the abort bit is set are ignored.
- R11: A start with an empty buffer completes with no port cycles. A control write with both bits set acts as an abort only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| port_data | output | 16 | Configuration word to the port |
| port_en | output | 1 | Port enable, high while a word is presented |
| port_wr | output | 1 | Port write direction, high with port_en |
| port_busy | input | 1 | Port stall request |

## Verification
A corrupted buffer pointer shows up at once in the vacancy field of the next status read, and it shows up as a wrong or missing word at the port within the same transfer. A broken stall path shows on the very next busy cycle as a changed port_data or a dropped enable, and the scoreboard then reports a lost or duplicated word. A faulty abort sequencer shows within three cycles as an abort bit that stays set or clears too early. It can also show as a data word being accepted inside the abort window, which the following vacancy read exposes.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 2'd0,
    RA_STAT  = 2'd1,
    RA_WDATA = 2'd2,
    RA_RSVD  = 2'd3
  } reg_addr_e;

  localparam int CTRL_WRITE_BIT = 0;
  localparam int CTRL_ABORT_BIT = 1;
  localparam int STAT_DONE_BIT  = 0;
  localparam int STAT_OVF_BIT   = 1;
  localparam int STAT_VAC_LSB   = 8;
endpackage

// File: rtl/cfgw_fifo.sv
// Write buffer: RAM with synchronous read, prefetched by the next read pointer.
// A bypass register covers a write landing on the address being read.
// DEPTH must be a power of two.
module cfgw_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    wr_ptr, rd_ptr, rd_ptr_nxt;
  logic [WIDTH-1:0] ram_q, byp_q;
  logic             byp_sel;
  logic             wr_fire, rd_fire;

  assign count   = wr_ptr - rd_ptr;
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wr_fire = wr_en && !full && !flush;
  assign rd_fire = rd_en && !empty && !flush;

  always_comb begin
    if (flush)        rd_ptr_nxt = '0;
    else if (rd_fire) rd_ptr_nxt = rd_ptr + CW'(1);
    else              rd_ptr_nxt = rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      rd_ptr <= rd_ptr_nxt;
      if (flush)        wr_ptr <= '0;
      else if (wr_fire) wr_ptr <= wr_ptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_data;
    ram_q <= mem[rd_ptr_nxt[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_sel <= 1'b0;
      byp_q   <= '0;
    end else begin
      byp_sel <= wr_fire && (wr_ptr[AW-1:0] == rd_ptr_nxt[AW-1:0]);
      byp_q   <= wr_data;
    end
  end

  assign rd_data = byp_sel ? byp_q : ram_q;
endmodule

// File: rtl/cfgw_drain.sv
// Transfer engine: registered port stage, one word per cycle, stalls on busy.
module cfgw_drain #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             flush,
  input  logic             halt,
  input  logic             fifo_empty,
  input  logic [WIDTH-1:0] fifo_head,
  output logic             fifo_pop,
  output logic             active,
  output logic             done,
  input  logic             port_busy,
  output logic [WIDTH-1:0] port_data,
  output logic             port_en,
  output logic             port_wr
);
  logic out_vld;
  logic accept, slot_free, load, finish;

  assign accept    = out_vld && !port_busy;
  assign slot_free = !out_vld || accept;
  assign load      = active && !halt && !fifo_empty && slot_free;
  assign finish    = active && !halt && fifo_empty && slot_free;
  assign fifo_pop  = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      done      <= 1'b0;
      out_vld   <= 1'b0;
      port_data <= '0;
    end else if (flush) begin
      active  <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      if (start && !active) begin
        active <= 1'b1;
        done   <= 1'b0;
      end
      if (load) begin
        out_vld   <= 1'b1;
        port_data <= fifo_head;
      end else if (accept) begin
        out_vld <= 1'b0;
      end
      if (finish) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign port_en = out_vld;
  assign port_wr = out_vld;
endmodule

// File: rtl/cfgw_regs.sv
// Register decode, abort sequencer, overflow flag and registered read mux.
module cfgw_regs
  import cfgw_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              active,
  input  logic              done,
  input  logic [CW-1:0]     fifo_count,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [WIDTH-1:0]  fifo_wdata,
  output logic              start,
  output logic              abort_q,
  output logic              flush,
  output logic              ovf_q
);
  reg_addr_e   addr;
  logic        ctrl_wr, abort_req;
  logic        flushed_q;
  logic [CW-1:0] vacancy;
  logic [BUS_W-1:0] ctrl_word, stat_word;
  logic        unused_hi;

  assign addr      = reg_addr_e'(bus_addr);
  assign ctrl_wr   = bus_wr && (addr == RA_CTRL);
  assign abort_req = ctrl_wr && bus_wdata[CTRL_ABORT_BIT];
  assign start     = ctrl_wr && bus_wdata[CTRL_WRITE_BIT] && !bus_wdata[CTRL_ABORT_BIT] && !abort_q;
  assign fifo_push = bus_wr && (addr == RA_WDATA) && !abort_q;
  assign fifo_wdata = bus_wdata[WIDTH-1:0];
  assign unused_hi = ^bus_wdata[BUS_W-1:WIDTH];
  assign flush     = abort_q && !flushed_q;
  assign vacancy   = CW'(DEPTH) - fifo_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_q   <= 1'b0;
      flushed_q <= 1'b0;
    end else if (!abort_q) begin
      abort_q <= abort_req;
    end else if (flushed_q) begin
      abort_q   <= 1'b0;
      flushed_q <= 1'b0;
    end else begin
      flushed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         ovf_q <= 1'b0;
    else if (flush)                  ovf_q <= 1'b0;
    else if (fifo_push && fifo_full) ovf_q <= 1'b1;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_WRITE_BIT] = active;
    ctrl_word[CTRL_ABORT_BIT] = abort_q;
    stat_word = '0;
    stat_word[STAT_DONE_BIT] = done;
    stat_word[STAT_OVF_BIT]  = ovf_q;
    stat_word[STAT_VAC_LSB +: CW] = vacancy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (addr)
        RA_CTRL: bus_rdata <= ctrl_word;
        RA_STAT: bus_rdata <= stat_word;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_writer.sv
module cfg_port_writer #(
  parameter int FIFO_DEPTH = 64,
  parameter int PORT_W = 16,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [PORT_W-1:0] port_data,
  output logic              port_en,
  output logic              port_wr,
  input  logic              port_busy
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [PORT_W-1:0] fifo_wdata, fifo_head;
  logic [CW-1:0]     fifo_count;
  logic              start, abort_q, flush, ovf_q;
  logic              drain_active, drain_done;

  cfgw_regs #(.DEPTH(FIFO_DEPTH), .WIDTH(PORT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .active(drain_active), .done(drain_done),
    .fifo_count(fifo_count), .fifo_full(fifo_full),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .start(start), .abort_q(abort_q), .flush(flush), .ovf_q(ovf_q)
  );

  cfgw_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(PORT_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(fifo_push), .wr_data(fifo_wdata),
    .rd_en(fifo_pop), .rd_data(fifo_head),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  cfgw_drain #(.WIDTH(PORT_W)) u_drain (
    .clk(clk), .rst(rst), .start(start), .flush(flush), .halt(abort_q),
    .fifo_empty(fifo_empty), .fifo_head(fifo_head), .fifo_pop(fifo_pop),
    .active(drain_active), .done(drain_done),
    .port_busy(port_busy), .port_data(port_data),
    .port_en(port_en), .port_wr(port_wr)
  );
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             port_en,
  input logic             port_busy,
  input logic [WIDTH-1:0] port_data,
  input logic             active,
  input logic             done,
  input logic             abort_q,
  input logic             flush,
  input logic             ovf_q,
  input logic [CW-1:0]    fifo_count
);
  a_r6_hold_on_busy: assert property (@(posedge clk) disable iff (rst)
    port_en && port_busy && !flush |=> port_en && $stable(port_data));

  a_r5_en_only_active: assert property (@(posedge clk) disable iff (rst)
    port_en |-> active);

  a_r7_done_vs_write: assert property (@(posedge clk) disable iff (rst)
    active |-> !done);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fifo_count == '0) && !port_en && !active);

  a_r10_abort_window: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_q) |=> abort_q ##1 !abort_q);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !flush |=> ovf_q);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));
endmodule

bind cfg_port_writer cfgw_checker #(.DEPTH(FIFO_DEPTH), .WIDTH(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .port_en(port_en), .port_busy(port_busy),
  .port_data(port_data), .active(drain_active), .done(drain_done),
  .abort_q(abort_q), .flush(flush), .ovf_q(ovf_q), .fifo_count(fifo_count)
);

// File: tb/test_cfg_port_writer.sv
module test_cfg_port_writer;
  localparam int DEPTH = 64;
  localparam int PW = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [PW-1:0] port_data;
  logic port_en, port_wr;
  logic port_busy = 1'b0;

  int checks = 0, fails = 0;
  int busy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic abort_zone = 1'b0;
  logic finished = 1'b0;
  logic [PW-1:0] exp_q [$];

  always #2 clk = ~clk;

  cfg_port_writer i_cfg_port_writer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_data(port_data), .port_en(port_en), .port_wr(port_wr),
    .port_busy(port_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // busy pattern, changed just after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    case (busy_mode)
      0: port_busy = 1'b0;
      1: port_busy = 1'b1;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        port_busy = lfsr[0] & lfsr[3];
      end
    endcase
  end

  // monitor: scoreboard pop on each accepted word, stall stability check
  logic prev_stall = 1'b0;
  logic [PW-1:0] prev_data = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && !abort_zone) begin
        check("R6 hold en", {31'd0, port_en}, 32'd1);
        check("R6 hold data", {16'd0, port_data}, {16'd0, prev_data});
      end
      if (port_en) check("R5 port_wr", {31'd0, port_wr}, 32'd1);
      if (port_en && !port_busy) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected word", {16'd0, port_data}, 32'hFFFF_FFFF);
        end else begin
          check("R5 word order", {16'd0, port_data}, {16'd0, exp_q.pop_front()});
        end
      end
      prev_stall = port_en && port_busy;
      prev_data  = port_data;
    end
  end

  // each op starts right after a falling edge and takes one cycle
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_word(input logic [PW-1:0] w, input bit expect_out);
    reg_write(A_DATA, {16'hDEAD, w});
    if (expect_out) exp_q.push_back(w);
  endtask

  function automatic logic [31:0] stat(input int vac, input bit ovf, input bit dn);
    return (32'(vac) << 8) | (32'(ovf) << 1) | 32'(dn);
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 3000; i++) begin
      reg_read(A_STAT, v);
      if (v[0]) begin seen = 1; break; end
    end
    check(req, {31'd0, seen}, 32'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 port_en", {31'd0, port_en}, 32'd0);
    reg_read(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    reg_read(A_STAT, v); check("R1 stat", v, stat(DEPTH, 0, 0));

    // R3/R2 load five words
    for (int i = 0; i < 5; i++) push_word(16'h1000 + 16'(i), 1);
    reg_read(A_STAT, v); check("R3 vacancy", v, stat(DEPTH - 5, 0, 0));
    reg_read(A_DATA, v); check("R2 data reg reads zero", v, 32'd0);

    // R4/R5/R7 plain drain
    reg_write(A_CTRL, 32'h1);
    reg_read(A_CTRL, v); check("R4 write bit set", v, 32'h1);
    wait_done("R7 done seen");
    reg_read(A_CTRL, v); check("R7 write bit cleared", v, 32'h0);
    check("R7 port_en low", {31'd0, port_en}, 32'd0);
    check("R7 all words out", 32'(exp_q.size()), 32'd0);

    // R6 random busy, twenty words; done cleared at start
    busy_mode = 2;
    for (int i = 0; i < 20; i++) push_word(16'hA500 ^ 16'(i * 37), 1);
    reg_write(A_CTRL, 32'h1);
    reg_read(A_STAT, v); check("R4 done cleared on start", v, stat(DEPTH - 20, 0, 0));
    wait_done("R6 done seen");
    check("R6 all words out", 32'(exp_q.size()), 32'd0);

    // R8 overflow
    busy_mode = 0;
    for (int i = 0; i < DEPTH + 3; i++) push_word(16'h3000 + 16'(i), i < DEPTH);
    reg_read(A_STAT, v); check("R8 full and overflow", v, stat(0, 1, 1));
    reg_write(A_CTRL, 32'h1);
    wait_done("R8 done seen");
    check("R8 kept words out", 32'(exp_q.size()), 32'd0);
    reg_read(A_STAT, v); check("R8 overflow sticky", v, stat(DEPTH, 1, 1));

    // R9/R10 abort during stalled transfer
    for (int i = 0; i < 10; i++) push_word(16'h5A00 + 16'(i), 0);
    busy_mode = 1;
    reg_write(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    abort_zone = 1'b1;
    reg_write(A_CTRL, 32'h2);
    reg_read(A_CTRL, v); check("R10 abort bit first cycle", v, 32'h3);
    reg_write(A_DATA, 32'h0000_BEEF);
    reg_read(A_CTRL, v); check("R10 abort bit cleared", v, 32'h0);
    reg_read(A_STAT, v); check("R9 flushed, ovf cleared, no done", v, stat(DEPTH, 0, 0));
    check("R9 port_en low", {31'd0, port_en}, 32'd0);
    busy_mode = 0;
    repeat (3) @(negedge clk);
    abort_zone = 1'b0;

    // R11 empty start, then combined bits act as abort
    reg_write(A_CTRL, 32'h1);
    wait_done("R11 empty start done");
    reg_read(A_CTRL, v); check("R11 write bit cleared", v, 32'h0);
    push_word(16'h7777, 0);
    push_word(16'h8888, 0);
    reg_write(A_CTRL, 32'h3);
    repeat (4) @(negedge clk);
    reg_read(A_STAT, v); check("R11 both bits act as abort", v, stat(DEPTH, 0, 1));
    reg_read(A_CTRL, v); check("R11 no transfer started", v, 32'h0);

    // R5 after abort, random busy
    busy_mode = 2;
    for (int i = 0; i < 12; i++) push_word(16'hC0DE - 16'(i), 1);
    reg_write(A_CTRL, 32'h1);
    wait_done("R5 done after abort");
    repeat (2) @(negedge clk);
    check("R5 all words out", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule